// File: doc/BRIEF.md
# Result-Slot Nonce Scanner

This block sits behind the read-back path of a hashing engine that reports results as seventeen 32-bit words. Sixteen of them are result slots that the engine overwrites in a scrambled form when it finds a nonce. The last word is a job tag. Each time a fresh read-back arrives, the block compares it with the copy it kept from an earlier poll. It looks at the slots only when the job tag has moved. Every slot whose content differs from the kept copy is unscrambled, and three candidate nonces are offered for each such slot on a valid/ready stream. Another unit tests the candidates against the target.

A poll is loaded in parallel with a valid strobe. While candidates are still pending, the block refuses new polls. A separate arm-clear input makes the next accepted poll act as the first one after reset: that poll only arms the block and yields nothing. A one-cycle done pulse ends the handling of every accepted poll.

Top module: `nonce_slot_scanner`

## Requirements
- R1: A raw slot word is unscrambled as follows. Result bits 31:24 are raw bits 7:0. Raw bits 31:8 form a 24-bit field `t` whose three bytes are each bit-reversed in place. Result bits 21:0 are `t[23:2]`, result bit 23 is `t[0]` and result bit 22 is `t[1]`.
- R2: The unscrambled value is the assembled word of R1 minus 0x00800004, modulo 2^32. For example, raw 0x00008000 gives 0xFFFFFFFC and raw 0x000000FF gives 0xFE7FFFFC.
- R3: Each unscrambled value `v` yields three candidates in this order: `v - 0x00800000`, then `v`, then `v - 0x00400000`, all modulo 2^32.
- R4: An accepted poll whose job tag (word 16, bits 543:512 of `res_data`) equals the kept tag yields no candidate.
- R5: When the tag differs, only slots 0 to 15 whose word differs from the kept copy are unscrambled. They are handled in ascending slot order, and all three candidates of a slot come before the next slot.
- R6: The first poll accepted after reset, or after a cycle with `arm_clr` high, yields no candidate and leaves the kept copy unchanged. It arms the block for later polls.
- R7: The kept 17-word copy is replaced by the poll only when the block is armed and the tag differed. A poll that has the same tag but changed slots does not alter it.
- R8: `res_ready` is low from the cycle after a poll that produces candidates is accepted until the last candidate is taken. A poll offered in that time is not consumed.
- R9: `scan_done` pulses for one cycle. It follows the cycle in which the last candidate was taken, or the accepting cycle when a poll yields no candidate.
- R10: While `cand_valid` is high and `cand_ready` is low, `cand_valid` and `cand_nonce` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_clr | input | 1 | Makes the next accepted poll a first poll |
| res_valid | input | 1 | Poll offered |
| res_ready | output | 1 | Poll can be accepted this cycle |
| res_data | input | 544 | Poll words, word i at bits [32*i+31:32*i], tag is word 16 |
| cand_valid | output | 1 | Candidate nonce offered |
| cand_ready | input | 1 | Consumer takes the candidate |
| cand_nonce | output | 32 | Candidate nonce |
| scan_done | output | 1 | One-cycle end-of-poll pulse |

## Verification
The hardest case to reach from the ports is a poll that keeps its tag but changes slots, followed by one that changes the tag. Only the second poll shows whether the kept copy was wrongly updated, through which slots count as changed. The bench builds that exact pair, then runs a phase that holds `res_valid` high with new data every cycle while the consumer stalls at random. In that phase, polls collide with scans in progress and with done pulses. A behavioural model with a candidate queue checks every cycle.

// File: rtl/nss_pkg.sv
package nss_pkg;

   localparam int unsigned NSS_WORD_W        = 32;
   localparam int unsigned NSS_CAND_PER_SLOT = 3;
   localparam logic [31:0] NSS_DECODE_BIAS   = 32'h0080_0004;

   // Offset subtracted for each candidate position; the order is observable.
   function automatic logic [31:0] nss_cand_offset(input logic [1:0] sel);
      case (sel)
         2'd0:    return 32'h0080_0000;
         2'd1:    return 32'h0000_0000;
         default: return 32'h0040_0000;
      endcase
   endfunction

endpackage

// File: rtl/nss_word_decode.sv
module nss_word_decode
   import nss_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic [WORD_W-1:0] raw,
   output logic [WORD_W-1:0] plain
);
   localparam int unsigned HEAD_W  = 8;
   localparam int unsigned TAIL_W  = WORD_W - HEAD_W;
   localparam int unsigned N_BYTES = TAIL_W / 8;

   logic [TAIL_W-1:0] flip;
   logic [WORD_W-1:0] assembled;

   generate
      if (WORD_W != NSS_WORD_W) begin : g_bad_width
         $error("nss_word_decode: WORD_W must be 32");
      end
      for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
         for (genvar j = 0; j < 8; j++) begin : g_bit
            assign flip[8*b + j] = raw[HEAD_W + 8*b + 7 - j];
         end
      end
   endgenerate

   assign assembled = {raw[HEAD_W-1:0], flip[0], flip[1], flip[TAIL_W-1:2]};
   assign plain     = assembled - NSS_DECODE_BIAS;

endmodule

// File: rtl/nss_first_pick.sv
module nss_first_pick #(
   parameter int unsigned N     = 16,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     mask,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     lowest,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = IDX_W'(i);
      end
   end

   assign lowest = mask & (~mask + N'(1));
   assign any    = |mask;

endmodule

// File: rtl/nss_result_store.sv
module nss_result_store #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load_en,
   input  logic [(NUM_SLOTS+1)*WORD_W-1:0] load_data,
   input  logic [IDX_W-1:0]                rd_idx,
   output logic [WORD_W-1:0]               rd_word,
   output logic [NUM_SLOTS-1:0]            diff_mask,
   output logic                            tag_moved
);
   localparam int unsigned TAG_LSB = NUM_SLOTS * WORD_W;

   logic [WORD_W-1:0] slot_q [NUM_SLOTS];
   logic [WORD_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
         tag_q <= '0;
      end else if (load_en) begin
         for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= load_data[i*WORD_W +: WORD_W];
         tag_q <= load_data[TAG_LSB +: WORD_W];
      end
   end

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
         assign diff_mask[g] = load_data[g*WORD_W +: WORD_W] != slot_q[g];
      end
   endgenerate

   assign tag_moved = load_data[TAG_LSB +: WORD_W] != tag_q;
   assign rd_word   = slot_q[rd_idx];

endmodule

// File: rtl/nss_scan_ctrl.sv
module nss_scan_ctrl #(
   parameter int unsigned NUM_SLOTS     = 16,
   parameter int unsigned CAND_PER_SLOT = 3,
   parameter int unsigned IDX_W         = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   parameter int unsigned OFS_W         = (CAND_PER_SLOT > 1) ? $clog2(CAND_PER_SLOT) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 res_valid,
   input  logic                 arm_clr,
   input  logic                 tag_moved,
   input  logic [NUM_SLOTS-1:0] diff_mask,
   input  logic                 cand_ready,
   output logic                 res_ready,
   output logic                 store_en,
   output logic                 cand_valid,
   output logic [IDX_W-1:0]     slot_idx,
   output logic [OFS_W-1:0]     ofs_sel,
   output logic                 scan_done,
   output logic                 armed
);
   logic                 armed_q, busy_q, done_q;
   logic [NUM_SLOTS-1:0] mask_q;
   logic [OFS_W-1:0]     ofs_q;
   logic [NUM_SLOTS-1:0] lowest;
   logic                 mask_any;
   logic                 accept, decode_go, launch, fire, last_ofs, final_fire;

   nss_first_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
      .mask   (mask_q),
      .idx    (slot_idx),
      .lowest (lowest),
      .any    (mask_any)
   );

   assign accept     = res_valid & ~busy_q;
   assign decode_go  = accept & armed_q & ~arm_clr & tag_moved;
   assign launch     = decode_go & (|diff_mask);
   assign fire       = busy_q & cand_ready;
   assign last_ofs   = ofs_q == OFS_W'(CAND_PER_SLOT - 1);
   assign final_fire = fire & last_ofs & ((mask_q & ~lowest) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         mask_q  <= '0;
         ofs_q   <= '0;
      end else begin
         if (accept)       armed_q <= 1'b1;
         else if (arm_clr) armed_q <= 1'b0;
         done_q <= (accept & ~launch) | final_fire;
         if (launch) begin
            busy_q <= 1'b1;
            mask_q <= diff_mask;
            ofs_q  <= '0;
         end else if (fire) begin
            if (last_ofs) begin
               ofs_q  <= '0;
               mask_q <= mask_q & ~lowest;
               if (final_fire) busy_q <= 1'b0;
            end else begin
               ofs_q <= ofs_q + OFS_W'(1);
            end
         end
      end
   end

   assign res_ready  = ~busy_q;
   assign store_en   = decode_go;
   assign cand_valid = busy_q & mask_any;
   assign ofs_sel    = ofs_q;
   assign scan_done  = done_q;
   assign armed      = armed_q;

endmodule

// File: rtl/nonce_slot_scanner.sv
module nonce_slot_scanner
   import nss_pkg::*;
#(
   parameter int unsigned WORD_W        = 32,
   parameter int unsigned NUM_SLOTS     = 16,
   parameter int unsigned CAND_PER_SLOT = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            arm_clr,
   input  logic                            res_valid,
   output logic                            res_ready,
   input  logic [(NUM_SLOTS+1)*WORD_W-1:0] res_data,
   output logic                            cand_valid,
   input  logic                            cand_ready,
   output logic [WORD_W-1:0]               cand_nonce,
   output logic                            scan_done
);
   localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam int unsigned OFS_W = 2;

   generate
      if (WORD_W != NSS_WORD_W) begin : g_chk_w
         $error("nonce_slot_scanner: WORD_W must be 32");
      end
      if (CAND_PER_SLOT != NSS_CAND_PER_SLOT) begin : g_chk_c
         $error("nonce_slot_scanner: CAND_PER_SLOT must be 3");
      end
      if (NUM_SLOTS < 1) begin : g_chk_s
         $error("nonce_slot_scanner: NUM_SLOTS must be at least 1");
      end
   endgenerate

   logic                 store_en, tag_moved, armed_w;
   logic [NUM_SLOTS-1:0] diff_mask;
   logic [IDX_W-1:0]     slot_idx;
   logic [OFS_W-1:0]     ofs_sel;
   logic [WORD_W-1:0]    slot_word, plain_word;

   nss_result_store #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (store_en),
      .load_data (res_data),
      .rd_idx    (slot_idx),
      .rd_word   (slot_word),
      .diff_mask (diff_mask),
      .tag_moved (tag_moved)
   );

   nss_scan_ctrl #(.NUM_SLOTS(NUM_SLOTS), .CAND_PER_SLOT(CAND_PER_SLOT),
                   .IDX_W(IDX_W), .OFS_W(OFS_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .res_valid  (res_valid),
      .arm_clr    (arm_clr),
      .tag_moved  (tag_moved),
      .diff_mask  (diff_mask),
      .cand_ready (cand_ready),
      .res_ready  (res_ready),
      .store_en   (store_en),
      .cand_valid (cand_valid),
      .slot_idx   (slot_idx),
      .ofs_sel    (ofs_sel),
      .scan_done  (scan_done),
      .armed      (armed_w)
   );

   nss_word_decode #(.WORD_W(WORD_W)) u_dec (
      .raw   (slot_word),
      .plain (plain_word)
   );

   assign cand_nonce = plain_word - nss_cand_offset(ofs_sel);

endmodule

// File: rtl/nss_checker.sv
module nss_checker #(
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm_clr,
   input logic              res_valid,
   input logic              res_ready,
   input logic              cand_valid,
   input logic              cand_ready,
   input logic [WORD_W-1:0] cand_nonce,
   input logic              scan_done,
   input logic              armed,
   input logic              tag_moved
);
   AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && !cand_ready) |=> cand_valid); // R10
   AST_HOLD_NONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && !cand_ready) |=> $stable(cand_nonce)); // R10
   AST_NO_LOAD_WHILE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> !res_ready); // R8
   AST_FIRST_POLL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ready && (!armed || arm_clr)) |=> (!cand_valid && scan_done)); // R6
   AST_SAME_TAG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ready && armed && !tag_moved) |=> (!cand_valid && scan_done)); // R4
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> !cand_valid); // R9
endmodule

bind nonce_slot_scanner nss_checker #(.WORD_W(WORD_W)) u_nss_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm_clr    (arm_clr),
   .res_valid  (res_valid),
   .res_ready  (res_ready),
   .cand_valid (cand_valid),
   .cand_ready (cand_ready),
   .cand_nonce (cand_nonce),
   .scan_done  (scan_done),
   .armed      (armed_w),
   .tag_moved  (tag_moved)
);

// File: tb/nonce_slot_scanner_bench.sv
`timescale 1ns/1ps
module nonce_slot_scanner_bench;
   localparam int NS = 16;
   localparam int NW = NS + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             arm_clr = 1'b0;
   logic             res_valid = 1'b0;
   logic             res_ready;
   logic [NW*32-1:0] res_data = '0;
   logic             cand_valid;
   logic             cand_ready = 1'b1;
   logic [31:0]      cand_nonce;
   logic             scan_done;

   int errors = 0;
   int checks = 0;
   bit stall_mode = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   nonce_slot_scanner u_nonce_slot_scanner (
      .clk(clk), .rst_n(rst_n), .arm_clr(arm_clr),
      .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
      .cand_valid(cand_valid), .cand_ready(cand_ready),
      .cand_nonce(cand_nonce), .scan_done(scan_done)
   );

   // ---------------- behavioural reference ----------------
   function automatic logic [31:0] ref_decode(input logic [31:0] raw);
      logic [23:0] r;
      logic [31:0] v;
      for (int b = 0; b < 3; b++)
         for (int j = 0; j < 8; j++)
            r[8*b + j] = raw[8 + 8*b + 7 - j];
      v = {raw[7:0], 24'h0} | {8'h0, r[0], r[1], r[23:2]};
      return v - 32'h0080_0004;
   endfunction

   logic [31:0] m_store [NW];
   logic [31:0] m_q [$];
   bit          m_armed;
   bit          m_done;
   bit          m_busy;
   bit          m_nd;
   logic [31:0] m_v;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++) m_store[i] = '0;
         m_q.delete();
         m_armed = 0;
         m_done  = 0;
      end else begin
         m_nd   = 0;
         m_busy = m_q.size() > 0;
         if (m_busy) begin
            if (cand_ready) begin
               void'(m_q.pop_front());
               if (m_q.size() == 0) m_nd = 1;
            end
         end else if (res_valid) begin
            if (!m_armed || arm_clr) m_nd = 1;
            else if (res_data[NS*32 +: 32] == m_store[NS]) m_nd = 1;
            else begin
               for (int s = 0; s < NS; s++) begin
                  if (res_data[s*32 +: 32] != m_store[s]) begin
                     m_v = ref_decode(res_data[s*32 +: 32]);
                     m_q.push_back(m_v - 32'h0080_0000);
                     m_q.push_back(m_v);
                     m_q.push_back(m_v - 32'h0040_0000);
                  end
               end
               for (int i = 0; i < NW; i++) m_store[i] = res_data[i*32 +: 32];
               if (m_q.size() == 0) m_nd = 1;
            end
         end
         if (!m_busy && res_valid) m_armed = 1;
         else if (arm_clr)         m_armed = 0;
         m_done = m_nd;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (res_ready !== (m_q.size() == 0)) begin
            errors++;
            $display("FAIL R8 res_ready act=%0b exp=%0b t=%0t", res_ready, m_q.size() == 0, $time);
         end
         checks++;
         if (cand_valid !== (m_q.size() > 0)) begin
            errors++;
            $display("FAIL R4 R5 R6 R7 cand_valid act=%0b exp=%0b t=%0t", cand_valid, m_q.size() > 0, $time);
         end
         checks++;
         if (scan_done !== m_done) begin
            errors++;
            $display("FAIL R9 scan_done act=%0b exp=%0b t=%0t", scan_done, m_done, $time);
         end
         if (m_q.size() > 0) begin
            checks++;
            if (cand_nonce !== m_q[0]) begin
               errors++;
               $display("FAIL R1 R2 R3 R5 R10 cand_nonce act=%h exp=%h t=%0t", cand_nonce, m_q[0], $time);
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic put(input int i, input logic [31:0] v);
      res_data[i*32 +: 32] = v;
   endtask

   task automatic poll();
      while (!res_ready) @(negedge clk);
      res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
      while (!res_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic randomize_slots(input int pct);
      for (int s = 0; s < NS; s++)
         if ($urandom_range(0, 99) < pct) put(s, $urandom);
   endtask

   // consumer readiness
   initial begin
      forever begin
         @(negedge clk);
         cand_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      end
   end

   // watchdog
   initial begin
      #3_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check_eq("R8 reset res_ready", 32'(res_ready), 32'd1);
      check_eq("R9 reset scan_done", 32'(scan_done), 32'd0);
      check_eq("R5 reset cand_valid", 32'(cand_valid), 32'd0);

      // reference decode spot values
      check_eq("R1 decode 0x000000FF", ref_decode(32'h0000_00FF), 32'hFE7F_FFFC);
      check_eq("R1 decode bit23 path", ref_decode(32'h0000_8000), 32'hFFFF_FFFC);
      check_eq("R1 decode bit22 path", ref_decode(32'h0000_4000), 32'hFFBF_FFFC);
      check_eq("R2 decode 0x00000100", ref_decode(32'h0000_0100), 32'hFF80_001C);

      // R6: first poll arms only
      for (int s = 0; s < NS; s++) put(s, 32'h1111_0000 + s);
      put(NS, 32'd1);
      poll();

      // first decoded poll: kept copy still zero, all slots differ
      put(0, 32'h0000_8000);
      put(1, 32'h0000_4000);
      put(2, 32'h0000_00FF);
      put(3, 32'h0000_0100);
      put(NS, 32'd2);
      while (!res_ready) @(negedge clk);
      res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
      check_eq("R3 first candidate", cand_nonce, 32'hFF7F_FFFC);
      @(negedge clk);
      check_eq("R3 second candidate", cand_nonce, 32'hFFFF_FFFC);
      @(negedge clk);
      check_eq("R3 third candidate", cand_nonce, 32'hFFBF_FFFC);
      @(negedge clk);
      check_eq("R5 next slot first", cand_nonce, 32'hFFBF_FFFC - 32'h0080_0000 + 32'h0040_0000 - 32'h0040_0000);
      while (!res_ready) @(negedge clk);
      @(negedge clk);

      // R4 and R7: same tag, changed slots -> silent, copy kept
      put(3, 32'hDEAD_BEEF);
      put(7, 32'hCAFE_0001);
      poll();
      // tag moves: slots 3 and 7 must still count as changed
      put(5, 32'h0BAD_F00D);
      put(NS, 32'd3);
      poll();
      // tag moves, no slot differs -> done only
      put(NS, 32'd4);
      poll();

      // stalled consumer, R10
      stall_mode = 1'b1;
      for (int n = 0; n < 6; n++) begin
         randomize_slots(40);
         put(NS, $urandom);
         poll();
      end

      // R6 via arm_clr
      @(negedge clk);
      arm_clr = 1'b1;
      @(negedge clk);
      arm_clr = 1'b0;
      randomize_slots(50);
      put(NS, 32'h77);
      poll();
      randomize_slots(50);
      put(NS, 32'h78);
      poll();

      // R8: valid held high, new data every cycle, collides with scans
      for (int n = 0; n < 120; n++) begin
         res_valid = 1'b1;
         randomize_slots(15);
         if ($urandom_range(0, 3) != 0) put(NS, $urandom);
         if ($urandom_range(0, 40) == 0) arm_clr = 1'b1; else arm_clr = 1'b0;
         @(negedge clk);
      end
      res_valid = 1'b0;
      arm_clr   = 1'b0;
      while (!res_ready) @(negedge clk);
      @(negedge clk);

      // random polls
      for (int n = 0; n < 40; n++) begin
         stall_mode = ($urandom_range(0, 1) == 1);
         randomize_slots(20);
         if ($urandom_range(0, 3) != 0) put(NS, $urandom);
         poll();
      end

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule